// File: doc/BRIEF.md
# Watermark Access Filter

This block sits in front of one on-chip memory and decides, for every bus access, whether the access may proceed. Each access brings a master number, a secure attribute, a privileged attribute and a kind: read, write or instruction fetch. Three regions are defined by start offsets inside the memory, and each region can be switched on or off. The regions are a secure zone, a privileged zone and a hide zone. The decision is combined with the identity and attributes of the master, and then the access is granted or blocked.

A blocked access never produces a bus error. A blocked read returns all zeros. A blocked write never reaches the memory. Every blocked access raises a single-cycle illegal-access event one cycle later. The hide zone is open after reset. A one-way disable request closes it, and only a reset opens it again. When the chip-level security enable is low, no check is made and every access is granted.

Top module: `wmf_access_filter`

## Requirements
- R1: When `glob_sec_en` is 0, every valid access is granted and no illegal event is raised, whatever its address, kind or attributes.
- R2: With `sec_zone_en` = 1, addresses `>= sec_zone_start` form the secure zone. A non-secure access (`req_secure` = 0) of any kind is denied there. Addresses below the start are not secure.
- R3: An address that lies in both the secure zone and the privileged zone is granted only to an access that is both secure and privileged. Such an access may also fetch instructions there.
- R4: With `priv_zone_en` = 1, addresses `>= priv_mark` are privileged and deny unprivileged accesses. Addresses below `priv_mark` accept unprivileged accesses.
- R5: A secure access may read and write outside the secure zone, but a secure instruction fetch outside the secure zone is denied.
- R6: An instruction fetch is denied for any master number whose bit in the parameter `EXEC_MASK` is 0.
- R7: With `hide_zone_en` = 1, addresses `>= hide_start` are the hide zone. It obeys the normal rules until a cycle with `hide_off_set` = 1 has been seen. From the next cycle on, every access to the zone is denied.
- R8: Once the hide zone is closed it stays closed, whatever `hide_off_set` does, until `rst_n` is asserted. After reset the zone is open again.
- R9: A granted read or fetch returns `mem_rdata` on `rsp_rdata`. A denied access, or a cycle with no access, returns zero.
- R10: `mem_we` is high only for a granted write. `mem_re` is high only for a granted read or fetch. A denied write leaves both low.
- R11: `illegal_evt` is high in the cycle after each denied valid access and low otherwise, so two denials in a row give two high cycles. It is low out of reset.
- R12: The `req_kind` code is 2'b00 read, 2'b01 write, 2'b10 fetch. The code 2'b11 is denied when checking is on, and it never moves data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| glob_sec_en | input | 1 | Chip-level enable for all checks |
| sec_zone_en | input | 1 | Secure zone enable |
| sec_zone_start | input | ADDR_W | First secure offset |
| priv_zone_en | input | 1 | Privileged zone enable |
| priv_mark | input | ADDR_W | First privileged offset |
| hide_zone_en | input | 1 | Hide zone enable |
| hide_start | input | ADDR_W | First hidden offset |
| hide_off_set | input | 1 | One-way request to close the hide zone |
| req_valid | input | 1 | Access present this cycle |
| req_addr | input | ADDR_W | Offset inside the memory |
| req_id | input | ID_W | Master number |
| req_secure | input | 1 | Secure attribute of the access |
| req_priv | input | 1 | Privileged attribute of the access |
| req_kind | input | 2 | Access kind code |
| mem_rdata | input | DATA_W | Read data from the memory |
| rsp_rdata | output | DATA_W | Read data returned to the master |
| grant | output | 1 | Access allowed |
| mem_re | output | 1 | Read strobe to the memory |
| mem_we | output | 1 | Write strobe to the memory |
| illegal_evt | output | 1 | Registered blocked-access pulse |

## Verification
The bench builds the filter with `ADDR_W` = 8 and `EXEC_MASK` = 4'b0011, so the master numbers 2 and 3 behave as data movers that may not fetch. The narrow offset width puts every zone boundary within reach of hand-picked addresses, such as one below and exactly at each start offset. The four master numbers let the execute mask be tested both ways. The bench then overlaps the zones, moves the watermarks between phases, and closes the hide zone and reopens it by reset.

// File: rtl/wmf_pkg.sv
package wmf_pkg;

   typedef enum logic [1:0] {
      ACC_RD  = 2'b00,
      ACC_WR  = 2'b01,
      ACC_EX  = 2'b10,
      ACC_RSV = 2'b11
   } acc_kind_t;

   typedef struct packed {
      logic sec;
      logic priv;
      logic hide;
   } zone_hits_t;

endpackage

// File: rtl/wmf_zone_decode.sv
module wmf_zone_decode
   import wmf_pkg::*;
#(
   parameter int ADDR_W = 18
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              sec_en,
   input  logic [ADDR_W-1:0] sec_start,
   input  logic              priv_en,
   input  logic [ADDR_W-1:0] priv_start,
   input  logic              hide_en,
   input  logic [ADDR_W-1:0] hide_from,
   output zone_hits_t        hits
);

   localparam int NZONE = 3;

   logic [NZONE-1:0]             zone_on;
   logic [NZONE-1:0][ADDR_W-1:0] zone_lo;
   logic [NZONE-1:0]             zone_hit;

   assign zone_on = {hide_en, priv_en, sec_en};
   assign zone_lo = {hide_from, priv_start, sec_start};

   for (genvar z = 0; z < NZONE; z++) begin : g_zone
      assign zone_hit[z] = zone_on[z] && (addr >= zone_lo[z]);
   end

   assign hits.sec  = zone_hit[0];
   assign hits.priv = zone_hit[1];
   assign hits.hide = zone_hit[2];

endmodule

// File: rtl/wmf_hide_lock.sv
module wmf_hide_lock (
   input  logic clk,
   input  logic rst_n,
   input  logic close_req,
   output logic closed
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         closed <= 1'b0;
      else if (close_req) closed <= 1'b1;
   end

   AST_HIDE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      closed |=> closed); // R8

   AST_HIDE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
      close_req |=> closed); // R7

endmodule

// File: rtl/wmf_policy.sv
module wmf_policy
   import wmf_pkg::*;
#(
   parameter int                ID_W      = 2,
   parameter logic [2**ID_W-1:0] EXEC_MASK = '1
) (
   input  logic            glob_en,
   input  zone_hits_t      hits,
   input  logic            hide_closed,
   input  logic [ID_W-1:0] mst_id,
   input  logic            mst_secure,
   input  logic            mst_priv,
   input  acc_kind_t       kind,
   output logic            allow
);

   localparam int NMST = 2**ID_W;

   logic [NMST-1:0] may_fetch;

   for (genvar m = 0; m < NMST; m++) begin : g_fetch
      assign may_fetch[m] = EXEC_MASK[m];
   end

   logic is_fetch, fetch_bad, priv_bad, sec_bad, hide_bad, kind_bad;

   always_comb begin
      is_fetch  = (kind == ACC_EX);
      kind_bad  = (kind == ACC_RSV);
      fetch_bad = is_fetch && (!may_fetch[mst_id] || (mst_secure && !hits.sec));
      priv_bad  = hits.priv && !mst_priv;
      sec_bad   = hits.sec && !mst_secure;
      hide_bad  = hits.hide && hide_closed;
      allow     = !glob_en || !(kind_bad || fetch_bad || priv_bad || sec_bad || hide_bad);
   end

endmodule

// File: rtl/wmf_access_filter.sv
module wmf_access_filter
   import wmf_pkg::*;
#(
   parameter int                 ADDR_W    = 18,
   parameter int                 DATA_W    = 32,
   parameter int                 ID_W      = 2,
   parameter logic [2**ID_W-1:0] EXEC_MASK = 4'b0011
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              glob_sec_en,
   input  logic              sec_zone_en,
   input  logic [ADDR_W-1:0] sec_zone_start,
   input  logic              priv_zone_en,
   input  logic [ADDR_W-1:0] priv_mark,
   input  logic              hide_zone_en,
   input  logic [ADDR_W-1:0] hide_start,
   input  logic              hide_off_set,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [ID_W-1:0]   req_id,
   input  logic              req_secure,
   input  logic              req_priv,
   input  logic [1:0]        req_kind,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              grant,
   output logic              mem_re,
   output logic              mem_we,
   output logic              illegal_evt
);

   if (ADDR_W < 4 || ADDR_W > 32) begin : g_bad_addr
      $error("wmf_access_filter: ADDR_W must lie in 4..32");
   end
   if (ID_W < 1 || ID_W > 4) begin : g_bad_id
      $error("wmf_access_filter: ID_W must lie in 1..4");
   end
   if (DATA_W < 8) begin : g_bad_data
      $error("wmf_access_filter: DATA_W must be at least 8");
   end

   zone_hits_t hits;
   logic       hide_closed;
   logic       allow;
   acc_kind_t  kind;

   assign kind = acc_kind_t'(req_kind);

   wmf_zone_decode #(.ADDR_W(ADDR_W)) u_decode (
      .addr       (req_addr),
      .sec_en     (sec_zone_en),
      .sec_start  (sec_zone_start),
      .priv_en    (priv_zone_en),
      .priv_start (priv_mark),
      .hide_en    (hide_zone_en),
      .hide_from  (hide_start),
      .hits       (hits)
   );

   wmf_hide_lock u_lock (
      .clk       (clk),
      .rst_n     (rst_n),
      .close_req (hide_off_set),
      .closed    (hide_closed)
   );

   wmf_policy #(.ID_W(ID_W), .EXEC_MASK(EXEC_MASK)) u_policy (
      .glob_en     (glob_sec_en),
      .hits        (hits),
      .hide_closed (hide_closed),
      .mst_id      (req_id),
      .mst_secure  (req_secure),
      .mst_priv    (req_priv),
      .kind        (kind),
      .allow       (allow)
   );

   logic reads;
   assign reads     = (kind == ACC_RD) || (kind == ACC_EX);
   assign grant     = req_valid && allow;
   assign mem_re    = grant && reads;
   assign mem_we    = grant && (kind == ACC_WR);
   assign rsp_rdata = mem_re ? mem_rdata : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) illegal_evt <= 1'b0;
      else        illegal_evt <= req_valid && !allow;
   end

   AST_GLOBAL_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !glob_sec_en) |-> grant); // R1

   AST_NS_SECURE_DENY: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && glob_sec_en && sec_zone_en && req_addr >= sec_zone_start && !req_secure) |-> !grant); // R2

   AST_SEC_NS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && glob_sec_en && req_secure && kind == ACC_EX &&
       !(sec_zone_en && req_addr >= sec_zone_start)) |-> !grant); // R5

   AST_EXEC_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && glob_sec_en && kind == ACC_EX && !EXEC_MASK[req_id]) |-> !grant); // R6

   AST_DENY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !grant |-> (rsp_rdata == '0)); // R9

   AST_DENY_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !grant |-> !mem_we); // R10

   AST_EVT_AFTER_DENY: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !grant) |=> illegal_evt); // R11

   AST_EVT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_evt |-> ($past(req_valid) && !$past(grant))); // R11

   AST_RSV_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == ACC_RSV) |-> (!mem_re && !mem_we)); // R12

endmodule

// File: tb/wmf_access_filter_test.sv
module wmf_access_filter_test;

   localparam int AW = 8;
   localparam int DW = 32;
   localparam int IW = 2;
   localparam logic [3:0] XMASK = 4'b0011;
   localparam logic [DW-1:0] MEMV = 32'hA5A5_1234;

   localparam logic [1:0] K_RD = 2'b00, K_WR = 2'b01, K_EX = 2'b10, K_RSV = 2'b11;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic          glob_sec_en = 0, sec_zone_en = 0, priv_zone_en = 0, hide_zone_en = 0;
   logic [AW-1:0] sec_zone_start = 0, priv_mark = 0, hide_start = 0;
   logic          hide_off_set = 0, req_valid = 0, req_secure = 0, req_priv = 0;
   logic [AW-1:0] req_addr = 0;
   logic [IW-1:0] req_id = 0;
   logic [1:0]    req_kind = 0;
   logic [DW-1:0] mem_rdata = MEMV;
   logic [DW-1:0] rsp_rdata;
   logic          grant, mem_re, mem_we, illegal_evt;

   wmf_access_filter #(.ADDR_W(AW), .DATA_W(DW), .ID_W(IW), .EXEC_MASK(XMASK)) uut (
      .clk(clk), .rst_n(rst_n), .glob_sec_en(glob_sec_en), .sec_zone_en(sec_zone_en),
      .sec_zone_start(sec_zone_start), .priv_zone_en(priv_zone_en), .priv_mark(priv_mark),
      .hide_zone_en(hide_zone_en), .hide_start(hide_start), .hide_off_set(hide_off_set),
      .req_valid(req_valid), .req_addr(req_addr), .req_id(req_id), .req_secure(req_secure),
      .req_priv(req_priv), .req_kind(req_kind), .mem_rdata(mem_rdata), .rsp_rdata(rsp_rdata),
      .grant(grant), .mem_re(mem_re), .mem_we(mem_we), .illegal_evt(illegal_evt)
   );

   // Configuration shadow, applied at the next driven cycle
   logic          c_glob = 0, c_sen = 0, c_pen = 0, c_hen = 0;
   logic [AW-1:0] c_sst = 0, c_pmk = 0, c_hst = 0;
   logic          m_hide_closed = 0;

   typedef struct {
      logic          g;
      logic          re;
      logic          we;
      logic          evt;
      logic [DW-1:0] rd;
      string         tag;
   } exp_t;

   exp_t q[$];
   int checks = 0;
   int failures = 0;
   bit done = 0;

   function automatic logic model_allow(logic [AW-1:0] a, logic [IW-1:0] id,
                                        logic s, logic p, logic [1:0] k);
      logic in_s, in_p, in_h;
      if (!c_glob) return 1'b1;
      in_s = c_sen && a >= c_sst;
      in_p = c_pen && a >= c_pmk;
      in_h = c_hen && a >= c_hst;
      if (k == K_RSV) return 1'b0;
      if (in_h && m_hide_closed) return 1'b0;
      if (k == K_EX && !XMASK[id]) return 1'b0;
      if (in_p && !p) return 1'b0;
      if (in_s) return s;
      if (k == K_EX && s) return 1'b0;
      return 1'b1;
   endfunction

   task automatic acc(input logic v, input logic [AW-1:0] a, input logic [IW-1:0] id,
                      input logic s, input logic p, input logic [1:0] k,
                      input logic hset, input string tag);
      exp_t e;
      logic ok;
      @(negedge clk);
      glob_sec_en = c_glob; sec_zone_en = c_sen; priv_zone_en = c_pen; hide_zone_en = c_hen;
      sec_zone_start = c_sst; priv_mark = c_pmk; hide_start = c_hst;
      req_valid = v; req_addr = a; req_id = id; req_secure = s; req_priv = p; req_kind = k;
      hide_off_set = hset;
      ok    = model_allow(a, id, s, p, k);
      e.g   = v && ok;
      e.re  = e.g && (k == K_RD || k == K_EX);
      e.we  = e.g && (k == K_WR);
      e.evt = v && !ok;
      e.rd  = e.re ? MEMV : '0;
      e.tag = tag;
      q.push_back(e);
      if (hset) m_hide_closed = 1'b1;
   endtask

   task automatic idle(input string tag);
      acc(1'b0, '0, '0, 1'b0, 1'b0, K_RD, 1'b0, tag);
   endtask

   task automatic do_reset();
      wait (q.size() == 0);
      @(negedge clk);
      req_valid = 0; hide_off_set = 0;
      rst_n = 0;
      m_hide_closed = 0;
      repeat (2) @(negedge clk);
      rst_n = 1;
   endtask

   // Monitor: compares after the edge that registers the event
   initial begin
      forever begin
         @(posedge clk);
         #3;
         if (rst_n && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (grant !== e.g || mem_re !== e.re || mem_we !== e.we ||
                illegal_evt !== e.evt || rsp_rdata !== e.rd) begin
               failures++;
               $display("FAIL %s: got g=%b re=%b we=%b evt=%b rd=%h exp g=%b re=%b we=%b evt=%b rd=%h",
                        e.tag, grant, mem_re, mem_we, illegal_evt, rsp_rdata,
                        e.g, e.re, e.we, e.evt, e.rd);
            end
         end
      end
   end

   initial begin
      #200000;
      if (!done) begin
         failures++;
         $display("FAIL watchdog: got hung run exp completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      checks++;
      if (illegal_evt !== 1'b0 || grant !== 1'b0 || mem_we !== 1'b0) begin
         failures++;
         $display("FAIL R11 reset: got evt=%b grant=%b we=%b exp 0 0 0", illegal_evt, grant, mem_we);
      end

      // R1: checking off, everything passes
      c_glob = 0; c_sen = 1; c_sst = 8'h80; c_pen = 1; c_pmk = 8'hC0; c_hen = 1; c_hst = 8'hF0;
      acc(1, 8'hF8, 2'd3, 0, 0, K_WR, 0, "R1 ns write into all zones");
      acc(1, 8'h90, 2'd3, 0, 0, K_EX, 0, "R1 masked fetch");
      acc(1, 8'h10, 2'd0, 0, 0, K_RSV, 0, "R1 R12 reserved kind no data");

      c_glob = 1;
      acc(1, 8'h10, 2'd0, 0, 0, K_RD, 0, "R9 granted read data");
      acc(1, 8'h20, 2'd0, 0, 0, K_WR, 0, "R10 granted write strobe");
      acc(1, 8'h80, 2'd3, 0, 1, K_RD, 0, "R2 ns read at secure start");
      acc(1, 8'h85, 2'd0, 0, 1, K_WR, 0, "R10 R2 ns write to secure dropped");
      acc(1, 8'h7F, 2'd0, 0, 0, K_EX, 0, "R2 ns fetch below secure start");
      acc(1, 8'hC4, 2'd1, 1, 1, K_EX, 0, "R3 secure priv fetch in overlap");
      acc(1, 8'hC0, 2'd1, 1, 0, K_RD, 0, "R3 secure unpriv read in overlap");
      acc(1, 8'hBF, 2'd1, 1, 0, K_RD, 0, "R4 below watermark unpriv");
      idle("R11 idle after deny");

      c_sen = 0; c_pmk = 8'h40;
      acc(1, 8'h40, 2'd0, 0, 0, K_RD, 0, "R4 unpriv at watermark");
      acc(1, 8'h40, 2'd0, 0, 1, K_RD, 0, "R4 priv at watermark");
      acc(1, 8'h3F, 2'd0, 0, 0, K_WR, 0, "R4 unpriv below watermark");

      c_sen = 1; c_pen = 0;
      acc(1, 8'h10, 2'd1, 1, 1, K_EX, 0, "R5 secure fetch outside secure zone");
      acc(1, 8'h10, 2'd1, 1, 1, K_RD, 0, "R5 secure read outside secure zone");
      acc(1, 8'h11, 2'd1, 1, 0, K_WR, 0, "R5 secure write outside secure zone");
      acc(1, 8'h90, 2'd2, 1, 1, K_EX, 0, "R6 masked master fetch");
      acc(1, 8'h90, 2'd2, 1, 1, K_RD, 0, "R6 masked master read");
      acc(1, 8'h10, 2'd0, 0, 0, K_EX, 0, "R6 enabled master fetch");
      acc(1, 8'h10, 2'd1, 1, 1, K_RSV, 0, "R12 reserved kind denied");

      // R11 back-to-back denials
      acc(1, 8'h90, 2'd0, 0, 0, K_RD, 0, "R11 first denial");
      acc(1, 8'h91, 2'd3, 0, 0, K_WR, 0, "R11 second denial");
      acc(1, 8'h01, 2'd0, 0, 0, K_RD, 0, "R11 grant clears event");

      // Hide zone
      acc(1, 8'hF0, 2'd1, 1, 1, K_RD, 0, "R7 hide open before disable");
      acc(0, 8'h00, 2'd0, 0, 0, K_RD, 1, "R7 disable request cycle");
      acc(1, 8'hF0, 2'd1, 1, 1, K_RD, 0, "R7 hide closed");
      acc(1, 8'hEF, 2'd1, 1, 1, K_RD, 0, "R7 below hide start");
      acc(1, 8'hFF, 2'd1, 1, 1, K_WR, 0, "R7 hide write dropped");
      idle("R8 idle");
      idle("R8 idle");
      acc(1, 8'hF4, 2'd1, 1, 1, K_EX, 0, "R8 still closed");
      do_reset();
      acc(1, 8'hF4, 2'd1, 1, 1, K_EX, 0, "R8 reopened by reset");

      wait (q.size() == 0);
      @(negedge clk);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule